// File: doc/BRIEF.md
# Tagged-Fetch Signature Watchdog

This block sits on the instruction fetch path between memory and a processor core. Every fetched word carries a two-bit tag. Words tagged as ordinary instructions pass straight through, and each one is added into a running 32-bit checksum for the current branch-free stretch of code. A word tagged as a reference signature is never executed. In the same bus cycle the block replaces it with a fixed no-operation word on the core side. It then compares the reference against the running checksum and clears the checksum for the next stretch.

A mismatch sets a sticky error flag. The block records the computed checksum and the reference value of the first mismatch and holds both until reset, so a fault handler can read them. A word that carries one of the two reserved tag values sets a separate sticky fault flag. Such a word does not take part in the checksum.

Top module: `ctrl_flow_sig_monitor`

## Requirements
- R1: After reset `sig_err_o` and `tag_fault_o` are 0, `err_calc_o` and `err_ref_o` are 0, and the running checksum is 0.
- R2: A valid word with tag 2'b00 is added to the running checksum modulo 2^32 at the next clock edge.
- R3: A valid word with tag 2'b01 is compared with the running checksum. On inequality, `sig_err_o` is 1 from the next clock edge.
- R4: After any valid tag 2'b01 word, whether or not it matches, the running checksum restarts from 0.
- R5: While `bus_valid_i` is 1 and the tag is 2'b01, `cpu_data_o` equals parameter `NOP_WORD` (default 32'hF0F0_0000) in the same cycle. At all other times it equals `bus_data_i`.
- R6: `sig_err_o` stays 1 until reset. `err_calc_o` and `err_ref_o` take the checksum and the reference of the first mismatch only, and later mismatches leave them unchanged.
- R7: A valid word with tag 2'b10 or 2'b11 sets `tag_fault_o`, which stays 1 until reset. Such a word leaves the checksum unchanged.
- R8: While `bus_valid_i` is 0, the tag and data are ignored: the checksum, the flags and the held values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Fetch word present on the bus |
| bus_tag_i | input | 2 | Word tag: 00 instruction, 01 signature, 10/11 reserved |
| bus_data_i | input | 32 | Fetched word from memory |
| cpu_data_o | output | 32 | Word delivered to the core (NOP on signature words) |
| sig_err_o | output | 1 | Sticky signature mismatch |
| tag_fault_o | output | 1 | Sticky reserved-tag fault |
| err_calc_o | output | 32 | Computed checksum at the first mismatch |
| err_ref_o | output | 32 | Reference signature at the first mismatch |

## Verification
The substituted word on `cpu_data_o` is combinational. It is checked 1 ns after the inputs change in the same cycle, well before the next rising edge. The flags and held values are due one edge after the word that causes them. The bench checks them at the following falling edge, against a behavioural model that is advanced once per driven cycle. The running checksum has no port of its own, so the scenarios observe it through whether the next signature word matches: an exact match proves the accumulation, wrap and restart behaviour.

// File: rtl/sigwd_pkg.sv
package sigwd_pkg;
  typedef enum logic [1:0] {
    TAG_INSN = 2'b00,
    TAG_SIG  = 2'b01,
    TAG_RSV2 = 2'b10,
    TAG_RSV3 = 2'b11
  } tag_e;
endpackage

// File: rtl/sigwd_accum.sv
module sigwd_accum #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic          clr_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (clr_i)  sum_o <= '0;
    else if (add_i)  sum_o <= sum_o + word_i; // wraps mod 2^DW
  end

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sum_o == '0); // R4
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_i && !clr_i) |=> $stable(sum_o)); // R8
endmodule

// File: rtl/sigwd_cmp.sv
module sigwd_cmp #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chk_i,
  input  logic [DW-1:0] calc_i,
  input  logic [DW-1:0] ref_i,
  output logic          err_o,
  output logic [DW-1:0] calc_o,
  output logic [DW-1:0] ref_o
);
  logic miss;
  assign miss = chk_i && (calc_i != ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      calc_o <= '0;
      ref_o  <= '0;
    end else if (miss && !err_o) begin
      err_o  <= 1'b1;
      calc_o <= calc_i;
      ref_o  <= ref_i;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R6
  AST_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> ($stable(calc_o) && $stable(ref_o))); // R6
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && calc_i != ref_i) |=> err_o); // R3
endmodule

// File: rtl/sigwd_nop_mux.sv
module sigwd_nop_mux #(
  parameter int          DW       = 32,
  parameter logic [31:0] NOP_WORD = 32'hF0F0_0000
) (
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam logic [DW-1:0] NopW = DW'(NOP_WORD);
  assign data_o = sel_i ? NopW : data_i;
endmodule

// File: rtl/ctrl_flow_sig_monitor.sv
module ctrl_flow_sig_monitor
  import sigwd_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] NOP_WORD = 32'hF0F0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [1:0]        bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              sig_err_o,
  output logic              tag_fault_o,
  output logic [DATA_W-1:0] err_calc_o,
  output logic [DATA_W-1:0] err_ref_o
);
  tag_e              tag;
  logic              is_insn, is_sig, is_rsv;
  logic [DATA_W-1:0] run_sum;

  assign tag     = tag_e'(bus_tag_i);
  assign is_insn = bus_valid_i && (tag == TAG_INSN);
  assign is_sig  = bus_valid_i && (tag == TAG_SIG);
  assign is_rsv  = bus_valid_i && (tag == TAG_RSV2 || tag == TAG_RSV3);

  sigwd_accum #(.DW(DATA_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (is_insn),
    .clr_i  (is_sig),
    .word_i (bus_data_i),
    .sum_o  (run_sum)
  );

  sigwd_cmp #(.DW(DATA_W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (is_sig),
    .calc_i (run_sum),
    .ref_i  (bus_data_i),
    .err_o  (sig_err_o),
    .calc_o (err_calc_o),
    .ref_o  (err_ref_o)
  );

  sigwd_nop_mux #(.DW(DATA_W), .NOP_WORD(NOP_WORD)) u_mux (
    .sel_i  (is_sig),
    .data_i (bus_data_i),
    .data_o (cpu_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tag_fault_o <= 1'b0;
    else if (is_rsv) tag_fault_o <= 1'b1;
  end

  AST_NOP_ON_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_tag_i == 2'b01) |-> cpu_data_o == DATA_W'(NOP_WORD)); // R5
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_i && bus_tag_i == 2'b01) |-> cpu_data_o == bus_data_i); // R5
  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_tag_i[1]) |=> tag_fault_o); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_fault_o |=> tag_fault_o); // R7
  AST_IDLE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> ($stable(sig_err_o) && $stable(tag_fault_o))); // R8
endmodule

// File: tb/sim_ctrl_flow_sig_monitor.sv
`timescale 1ns/1ps
module sim_ctrl_flow_sig_monitor;
  localparam logic [31:0] NOP = 32'hF0F0_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  tag = 2'b00;
  logic [31:0] data = '0;
  logic [31:0] cpu_data;
  logic        sig_err, tag_fault;
  logic [31:0] err_calc, err_ref;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [31:0] m_sum = '0;
  logic        m_err = 1'b0;
  logic        m_fault = 1'b0;
  logic [31:0] m_calc = '0;
  logic [31:0] m_ref = '0;

  always #2 clk = ~clk;

  ctrl_flow_sig_monitor u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bus_valid_i (valid),
    .bus_tag_i   (tag),
    .bus_data_i  (data),
    .cpu_data_o  (cpu_data),
    .sig_err_o   (sig_err),
    .tag_fault_o (tag_fault),
    .err_calc_o  (err_calc),
    .err_ref_o   (err_ref)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, "sig_err", {31'b0, sig_err}, {31'b0, m_err});
    chk(req, "tag_fault", {31'b0, tag_fault}, {31'b0, m_fault});
    chk(req, "err_calc", err_calc, m_calc);
    chk(req, "err_ref", err_ref, m_ref);
  endtask

  // one bus cycle: check registered outputs, drive, check mux, advance model
  task automatic step(string req, logic v, logic [1:0] t, logic [31:0] d);
    @(negedge clk);
    chk_regs(req);
    valid = v; tag = t; data = d;
    #1;
    chk("R5", "cpu_data", cpu_data, (v && t == 2'b01) ? NOP : d);
    if (v) begin
      case (t)
        2'b00: m_sum = m_sum + d;
        2'b01: begin
          if (m_sum != d && !m_err) begin
            m_err = 1'b1; m_calc = m_sum; m_ref = d;
          end
          m_sum = '0;
        end
        default: m_fault = 1'b1;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 1'b0; rst_ni = 1'b0;
    m_sum = '0; m_err = 1'b0; m_fault = 1'b0; m_calc = '0; m_ref = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk_regs("R1");
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 1'b0, 2'b00, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R2: modulo wrap, exact match expected
    step("R2", 1, 2'b00, 32'hFFFF_FFF0);
    step("R2", 1, 2'b00, 32'h0000_0020);
    step("R2", 1, 2'b01, 32'h0000_0010);
    idle("R2", 1);
    chk("R2", "no error after wrap match", {31'b0, sig_err}, 32'd0);

    // R4: restart after compare
    step("R4", 1, 2'b00, 32'd5);
    step("R4", 1, 2'b00, 32'd6);
    step("R4", 1, 2'b01, 32'd11);
    step("R4", 1, 2'b00, 32'd7);
    step("R4", 1, 2'b01, 32'd7);
    step("R4", 1, 2'b01, 32'd0);  // empty interval sums to zero
    idle("R4", 1);
    chk("R4", "restart match", {31'b0, sig_err}, 32'd0);

    // R8: invalid cycles with junk ignored
    step("R8", 0, 2'b01, 32'hDEAD_BEEF);
    step("R8", 0, 2'b11, 32'h1234_5678);
    step("R8", 1, 2'b00, 32'd3);
    step("R8", 0, 2'b00, 32'h0000_1000);
    step("R8", 1, 2'b01, 32'd3);
    idle("R8", 1);
    chk("R8", "idle ignored", {31'b0, sig_err | tag_fault}, 32'd0);

    // R7: reserved tags fault, not accumulated
    step("R7", 1, 2'b00, 32'd4);
    step("R7", 1, 2'b10, 32'd100);
    step("R7", 1, 2'b11, 32'd200);
    step("R7", 1, 2'b01, 32'd4);
    idle("R7", 2);
    chk("R7", "tag_fault set", {31'b0, tag_fault}, 32'd1);
    chk("R7", "reserved not summed", {31'b0, sig_err}, 32'd0);

    // R3 / R6: mismatch, capture first, hold
    step("R3", 1, 2'b00, 32'd1);
    step("R3", 1, 2'b01, 32'd2);
    idle("R3", 1);
    chk("R3", "sig_err set", {31'b0, sig_err}, 32'd1);
    chk("R6", "calc captured", err_calc, 32'd1);
    chk("R6", "ref captured", err_ref, 32'd2);
    step("R6", 1, 2'b00, 32'd9);
    step("R6", 1, 2'b01, 32'd5);
    idle("R6", 3);
    chk("R6", "calc held", err_calc, 32'd1);
    chk("R6", "ref held", err_ref, 32'd2);

    // R1: reset clears everything
    do_reset();
    step("R1", 1, 2'b00, 32'hAAAA_0000);
    step("R1", 1, 2'b01, 32'hAAAA_0000);
    idle("R1", 1);
    chk("R1", "clean after reset", {31'b0, sig_err}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule